// File: doc/BRIEF.md
# Register-Controlled Clock Divider with Selectable Divisor Encoding

This block derives a slower clock from its input clock with a period counter. The division ratio is held in a small bit field of a control word written through a single-cycle write port. The field's position (`SHIFT`) and size (`WIDTH`) are parameters. A compile-time encoding chooses how the stored field becomes a divisor D:

- field plus one
- the raw field value
- two raised to the field value
- a small lookup table of value/divisor pairs

A ratio of one, or a permitted zero, routes the input clock straight to the output. A field with no meaning forces the output low and raises an error flag.

A ratio change never cuts a period short. The counter finishes the period it is in before it adopts the new setting. With the rate-gate option, the output is also held low for one whole period of the new ratio. The write port can use a masked-write form: the field lives in the lower half-word, and each field bit changes only when its companion enable bit, 16 positions higher, is set. The block has no data stream, so every pin is a plain control or clock pin.

Top module: `clkdiv_field`

## Requirements
- R1: Field location and field-plus-one encoding. The field is `wr_data_i[SHIFT+WIDTH-1:SHIFT]` (default bits [6:4]). In the field-plus-one encoding, D equals the field plus 1.
- R2: In the raw encoding, D equals the field. When zero is not permitted, a zero field is invalid: `clk_o` stays low and `err_o` is 1.
- R3: A zero field in the raw encoding with zero permitted, or any D of 1, passes the input clock: `clk_o` is high in the high half of each input cycle and low in the low half.
- R4: In the power-of-two encoding, D equals 2 raised to the field.
- R5: In the table encoding, entries are scanned in index order. An entry whose divisor is 0 ends the table. A field that matches no entry before the end is invalid: `clk_o` stays low and `err_o` is 1. The default table maps 0 to 2, 1 to 3 and 3 to 5, with entry 3 (value 5) ending the table.
- R6: For D of 2 or more, each output period lasts D input cycles. It opens with floor(D/2) high cycles, followed by D - floor(D/2) low cycles.
- R7: In masked-write mode, field bit b changes only when bit 16+SHIFT+b of the written word is 1. In plain mode, a write loads the field and every other written bit has no effect.
- R8: A new ratio takes effect only once the current output period has completed.
- R9: With the rate-gate option, the first period of a new setting is held entirely low. Normal output follows.
- R10: While reset is asserted, `clk_o` and `err_o` are 0 and the field is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low reset, synchronous to `clk_i` |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | REG_W | Control word; field at `SHIFT`, enables at `16+SHIFT` in masked mode |
| clk_o | output | 1 | Divided clock, or the input clock in pass-through |
| err_o | output | 1 | The active field is invalid |

## Verification
The bound checker watches on every cycle that:
- an invalid or gated setting never drives the divided output high;
- the period counter stays below the active divisor;
- every rising output edge opens a period;
- the active divisor cannot move in the middle of a period;
- masked-off writes leave the field untouched.

Only the bench scenarios can show the following:
- the measured high and low phase lengths for every field value in every encoding;
- the table terminator;
- the undivided pass-through waveform;
- the exact stretched low phase caused by rate gating;
- the completion of a long period after a short ratio is written in its middle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    ENC_PLUS1 = 2'd0,
    ENC_RAW   = 2'd1,
    ENC_POW2  = 2'd2,
    ENC_TABLE = 2'd3
  } enc_mode_e;

  localparam int MASK_OFS = 16;
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg #(
  parameter int REG_W     = 32,
  parameter int SHIFT     = 4,
  parameter int WIDTH     = 3,
  parameter bit MASKED_WR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [WIDTH-1:0] field_o
);
  import clkdiv_pkg::*;

  logic [WIDTH-1:0] field_q, field_d;
  logic             spare_unused;

  assign spare_unused = ^wr_data_i;

  generate
    if (MASKED_WR) begin : g_masked
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign field_d[b] = wr_data_i[MASK_OFS+SHIFT+b] ? wr_data_i[SHIFT+b] : field_q[b];
      end
    end else begin : g_plain
      assign field_d = wr_data_i[SHIFT +: WIDTH];
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      field_q <= '0;
    else if (wr_en_i) field_q <= field_d;
  end

  assign field_o = field_q;
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter int                      WIDTH      = 3,
  parameter int                      DIV_W      = 4,
  parameter clkdiv_pkg::enc_mode_e   MODE       = clkdiv_pkg::ENC_PLUS1,
  parameter bit                      ALLOW_ZERO = 1'b0,
  parameter int                      TBL_N      = 4,
  parameter logic [TBL_N*WIDTH-1:0]  TBL_VAL    = '0,
  parameter logic [TBL_N*DIV_W-1:0]  TBL_DIV    = '0
) (
  input  logic [WIDTH-1:0] field_i,
  output logic [DIV_W-1:0] div_o,
  output logic             pass_o,
  output logic             bad_o
);
  import clkdiv_pkg::*;

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_raw;
  logic             zero_pass;
  logic             invalid;

  generate
    if (MODE == ENC_PLUS1) begin : g_plus1
      always_comb begin
        div_raw   = DIV_W'(field_i) + ONE;
        zero_pass = 1'b0;
        invalid   = 1'b0;
      end
    end else if (MODE == ENC_RAW) begin : g_raw
      always_comb begin
        div_raw   = (field_i == '0) ? ONE : DIV_W'(field_i);
        zero_pass = (field_i == '0) && ALLOW_ZERO;
        invalid   = (field_i == '0) && !ALLOW_ZERO;
      end
    end else if (MODE == ENC_POW2) begin : g_pow2
      always_comb begin
        div_raw   = ONE << field_i;
        zero_pass = 1'b0;
        invalid   = 1'b0;
      end
    end else begin : g_table
      logic live, found;
      always_comb begin
        div_raw   = ONE;
        found     = 1'b0;
        live      = 1'b1;
        zero_pass = 1'b0;
        for (int i = 0; i < TBL_N; i++) begin
          if (TBL_DIV[i*DIV_W +: DIV_W] == '0) begin
            live = 1'b0;
          end else if (live && !found && (TBL_VAL[i*WIDTH +: WIDTH] == field_i)) begin
            found   = 1'b1;
            div_raw = TBL_DIV[i*DIV_W +: DIV_W];
          end
        end
        invalid = !found;
      end
    end
  endgenerate

  assign div_o  = div_raw;
  assign bad_o  = invalid;
  assign pass_o = !invalid && (zero_pass || (div_raw == ONE));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int DIV_W     = 4,
  parameter bit RATE_GATE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] new_div_i,
  input  logic             new_pass_i,
  input  logic             new_bad_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] act_div_o,
  output logic             act_pass_o,
  output logic             act_bad_o,
  output logic             gate_o,
  output logic             out_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d, div_q, div_d;
  logic             pass_q, pass_d, bad_q, bad_d, gate_q, gate_d, out_q, out_d;
  logic             at_end, differs;

  assign at_end  = pass_q | bad_q | (cnt_q == div_q - ONE);
  assign differs = (new_div_i != div_q) | (new_pass_i != pass_q) | (new_bad_i != bad_q);

  always_comb begin
    cnt_d  = cnt_q + ONE;
    div_d  = div_q;
    pass_d = pass_q;
    bad_d  = bad_q;
    gate_d = gate_q;
    if (at_end) begin
      cnt_d  = '0;
      div_d  = new_div_i;
      pass_d = new_pass_i;
      bad_d  = new_bad_i;
      gate_d = RATE_GATE && differs;
    end
    out_d = !pass_d && !bad_d && !gate_d && (cnt_d < (div_d >> 1));
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= ONE;
      pass_q <= 1'b0;
      bad_q  <= 1'b0;
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      pass_q <= pass_d;
      bad_q  <= bad_d;
      gate_q <= gate_d;
      out_q  <= out_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign act_div_o  = div_q;
  assign act_pass_o = pass_q;
  assign act_bad_o  = bad_q;
  assign gate_o     = gate_q;
  assign out_o      = out_q;
endmodule

// File: rtl/clkdiv_field.sv
module clkdiv_field #(
  parameter int                    REG_W      = 32,
  parameter int                    SHIFT      = 4,
  parameter int                    WIDTH      = 3,
  parameter clkdiv_pkg::enc_mode_e MODE       = clkdiv_pkg::ENC_PLUS1,
  parameter bit                    ALLOW_ZERO = 1'b0,
  parameter bit                    MASKED_WR  = 1'b0,
  parameter bit                    RATE_GATE  = 1'b0,
  parameter int                    TBL_N      = 4,
  parameter int                    TDIV_W     = 8,
  parameter logic [TBL_N*WIDTH-1:0]  TBL_VAL  = {3'd5, 3'd3, 3'd1, 3'd0},
  parameter logic [TBL_N*TDIV_W-1:0] TBL_DIV  = {8'd0, 8'd5, 8'd3, 8'd2}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             clk_o,
  output logic             err_o
);
  import clkdiv_pkg::*;

  localparam int DIV_W = (MODE == ENC_POW2)  ? (2 ** WIDTH) :
                         (MODE == ENC_TABLE) ? TDIV_W : (WIDTH + 1);

  logic [WIDTH-1:0] field;
  logic [DIV_W-1:0] new_div, act_div, cnt;
  logic             new_pass, new_bad, act_pass, act_bad, gate, out_q;

  clkdiv_ctrl_reg #(
    .REG_W(REG_W), .SHIFT(SHIFT), .WIDTH(WIDTH), .MASKED_WR(MASKED_WR)
  ) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .field_o(field)
  );

  clkdiv_decode #(
    .WIDTH(WIDTH), .DIV_W(DIV_W), .MODE(MODE), .ALLOW_ZERO(ALLOW_ZERO),
    .TBL_N(TBL_N), .TBL_VAL(TBL_VAL), .TBL_DIV(TBL_N*DIV_W'(0) + TBL_DIV)
  ) u_dec (
    .field_i(field), .div_o(new_div), .pass_o(new_pass), .bad_o(new_bad)
  );

  clkdiv_counter #(
    .DIV_W(DIV_W), .RATE_GATE(RATE_GATE)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .new_div_i(new_div), .new_pass_i(new_pass), .new_bad_i(new_bad),
    .cnt_o(cnt), .act_div_o(act_div), .act_pass_o(act_pass),
    .act_bad_o(act_bad), .gate_o(gate), .out_o(out_q)
  );

  assign clk_o = (act_pass && !gate) ? clk_i : out_q;
  assign err_o = act_bad;
endmodule

// File: rtl/clkdiv_field_chk.sv
module clkdiv_field_chk #(
  parameter int WIDTH     = 3,
  parameter int DIV_W     = 4,
  parameter bit MASKED_WR = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [WIDTH-1:0] wr_mask,
  input logic [WIDTH-1:0] field,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] act_div,
  input logic             act_pass,
  input logic             act_bad,
  input logic             gate,
  input logic             out_q
);
  // R2 and R5: an invalid setting keeps the divided output low
  p_bad_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_bad |-> !out_q);

  // R9: gated period keeps the divided output low
  p_gate_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate |-> !out_q);

  // R6: counter never reaches the divisor
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_pass && !act_bad) |-> (cnt < act_div));

  // R6: a rising output edge opens a period
  p_rise_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> (cnt == '0));

  // R8: divisor cannot change in mid-period
  p_period_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_pass && !act_bad && (cnt != act_div - DIV_W'(1))) |=> $stable(act_div));

  // R7: masked-off write bits leave the field unchanged
  p_mask_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MASKED_WR && wr_en_i && (wr_mask == '0)) |=> $stable(field));
endmodule

bind clkdiv_field clkdiv_field_chk #(
  .WIDTH(WIDTH), .DIV_W(DIV_W), .MASKED_WR(MASKED_WR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .wr_mask(wr_data_i[clkdiv_pkg::MASK_OFS+SHIFT +: WIDTH]),
  .field(field), .cnt(cnt), .act_div(act_div), .act_pass(act_pass),
  .act_bad(act_bad), .gate(gate), .out_q(out_q)
);

// File: tb/clkdiv_field_tb.sv
module clkdiv_field_tb;
  import clkdiv_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wdata = '0;
  logic [4:0]  wen = '0;
  wire  [4:0]  co;
  wire  [4:0]  er;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  // 0: field+1, plain  1: raw, zero allowed, masked, rate gate
  // 2: raw, zero invalid  3: power of two  4: table
  clkdiv_field #(.MODE(ENC_PLUS1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen[0]), .wr_data_i(wdata), .clk_o(co[0]), .err_o(er[0]));
  clkdiv_field #(.MODE(ENC_RAW), .ALLOW_ZERO(1'b1), .MASKED_WR(1'b1), .RATE_GATE(1'b1)) u_raw (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen[1]), .wr_data_i(wdata), .clk_o(co[1]), .err_o(er[1]));
  clkdiv_field #(.MODE(ENC_RAW)) u_rawn (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen[2]), .wr_data_i(wdata), .clk_o(co[2]), .err_o(er[2]));
  clkdiv_field #(.MODE(ENC_POW2)) u_pow (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen[3]), .wr_data_i(wdata), .clk_o(co[3]), .err_o(er[3]));
  clkdiv_field #(.MODE(ENC_TABLE)) u_tbl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen[4]), .wr_data_i(wdata), .clk_o(co[4]), .err_o(er[4]));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    step();
    wdata  = d;
    wen[i] = 1'b1;
    step();
    wen[i] = 1'b0;
  endtask

  function automatic logic [31:0] fdat(input int f, input bit masked);
    return (32'(f) << 4) | (masked ? 32'h0070_0000 : 32'h0);
  endfunction

  // 0 means invalid, 1 means pass-through
  function automatic int exp_div(input int i, input int f);
    case (i)
      0: return f + 1;
      1: return (f == 0) ? 1 : f;
      2: return f;
      3: return 1 << f;
      default: case (f)
        0: return 2;
        1: return 3;
        3: return 5;
        default: return 0;
      endcase
    endcase
  endfunction

  task automatic run_len(input int i, output int n);
    logic v;
    v = co[i];
    n = 0;
    while ((co[i] == v) && (n < 600)) begin
      n++;
      step();
    end
  endtask

  task automatic wait_rise(input int i, output bit ok);
    logic prev;
    ok = 1'b0;
    step();
    prev = co[i];
    for (int k = 0; k < 400 && !ok; k++) begin
      step();
      if (!prev && co[i]) ok = 1'b1;
      prev = co[i];
    end
  endtask

  task automatic check_wave(input int i, input int d, input string req);
    bit ok;
    int h, l;
    wait_rise(i, ok);
    if (!ok) begin
      chk(1'b0, req, "no rising edge found", 0, d);
    end else begin
      run_len(i, h);
      run_len(i, l);
      chk(h == d / 2, req, "high phase length", h, d / 2);
      chk(l == d - d / 2, req, "low phase length", l, d - d / 2);
      chk(er[i] == 1'b0, req, "error flag", int'(er[i]), 0);
    end
  endtask

  task automatic check_pass(input int i, input string req);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk(co[i] == 1'b1, req, "pass-through high half", int'(co[i]), 1);
      @(negedge clk); #1;
      chk(co[i] == 1'b0, req, "pass-through low half", int'(co[i]), 0);
    end
    chk(er[i] == 1'b0, req, "error flag in pass-through", int'(er[i]), 0);
  endtask

  task automatic check_bad(input int i, input string req);
    int hi;
    hi = 0;
    repeat (20) begin
      step();
      if (co[i]) hi++;
    end
    chk(hi == 0, req, "output high samples while invalid", hi, 0);
    chk(er[i] == 1'b1, req, "error flag while invalid", int'(er[i]), 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired, run incomplete actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    string tag;
    int    d, h, l;
    bit    ok;

    // R10: reset state
    repeat (4) step();
    chk(co == 5'b0, "R10", "clk_o during reset", int'(co), 0);
    chk(er == 5'b0, "R10", "err_o during reset", int'(er), 0);
    rst_n = 1'b1;

    // Field sweep over every encoding
    for (int i = 0; i < 5; i++) begin
      for (int f = 0; f < 8; f++) begin
        wr(i, fdat(f, i == 1));
        repeat (280) @(posedge clk);
        d = exp_div(i, f);
        case (i)
          0: tag = "R1";
          1: tag = "R2";
          2: tag = "R2";
          3: tag = "R4";
          default: tag = "R5";
        endcase
        if (d == 0)      check_bad(i, tag);
        else if (d == 1) check_pass(i, "R3");
        else             check_wave(i, d, (f == 1 || f == 7) ? "R6" : tag);
      end
    end

    // R8: write a short ratio in the middle of a long period
    wr(0, fdat(7, 1'b0));
    repeat (40) step();
    wait_rise(0, ok);
    chk(ok, "R8", "rising edge before change", int'(ok), 1);
    step();
    wdata  = fdat(1, 1'b0);
    wen[0] = 1'b1;
    step();
    wen[0] = 1'b0;
    run_len(0, h);
    h = h + 2;
    run_len(0, l);
    chk(h == 4, "R8", "old period high phase kept", h, 4);
    chk(l == 4, "R8", "old period low phase kept", l, 4);
    run_len(0, h);
    run_len(0, l);
    chk(h == 1 && l == 1, "R8", "new period length", h + l, 2);

    // R9: rate gate holds the first new period low
    wr(1, fdat(4, 1'b1));
    repeat (60) step();
    wait_rise(1, ok);
    chk(ok, "R9", "rising edge before change", int'(ok), 1);
    wdata  = fdat(6, 1'b1);
    wen[1] = 1'b1;
    step();
    wen[1] = 1'b0;
    run_len(1, h);
    h = h + 1;
    run_len(1, l);
    chk(h == 2, "R9", "old high phase", h, 2);
    chk(l == 8, "R9", "low run including gated period", l, 8);
    run_len(1, h);
    run_len(1, l);
    chk(h == 3 && l == 3, "R9", "first ungated period", h * 10 + l, 33);

    // R7: write with field enables clear leaves the ratio at 6
    wr(1, (32'd2 << 4) | 32'hFF80_0000);
    repeat (60) step();
    check_wave(1, 6, "R7");
    // R7: only bit 0 enabled, 110 becomes 111
    wr(1, (32'd1 << 4) | (32'd1 << 20));
    repeat (60) step();
    check_wave(1, 7, "R7");
    // R7: plain mode ignores bits outside the field (field = 3, D = 8)
    wr(3, 32'hFFFF_FFBF);
    repeat (280) @(posedge clk);
    check_wave(3, 8, "R7");

    summary();
    $finish;
  end
endmodule